// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Cell

This block is one programmable logic cell. Up to sixteen product-term inputs, each with its own enable bit, are ORed into a sum. A two-input XOR follows. Its second input comes from a four-way select, which gives a true or complemented sum, an XOR with the local carry, or a toggle path that turns the D flip-flop into a T flip-flop. The local carry is chosen from two carry product terms by the incoming carry, and the incoming carry can be cut off per cell. The same local carry is driven out as the carry output.

The cell flip-flop has four parts: a clock-source select covering the global clocks and a product-term clock, a per-cell edge polarity bit, and separate asynchronous preset and clear. Preset and clear each pick one of two control product terms or ground. An output select presents either the registered value or the combinational XOR result. Every configuration bit is a static input. The cell is meant to be placed many times, under configuration that software writes once.

Top module: `pterm_macrocell`

## Requirements
- R1: The sum is the OR of `pt_in[i] & pt_en[i]` over all terms. A term whose enable bit is 0 adds nothing, whatever its input.
- R2: `xor_sel` picks the second XOR input: 0 gives the true sum, 1 gives the complemented sum, 2 gives the sum XOR the local carry, and 3 gives the sum XOR the register output.
- R3: The local carry equals `cpt1` when `carry_in & chain_en` is 1 and `cpt0` otherwise. `carry_out` always equals the local carry, so `chain_en = 0` blocks the incoming carry.
- R4: When `out_reg` is 0, `cell_out` is the combinational XOR result. When it is 1, `cell_out` is the register value.
- R5: `clk_sel` values 0 to 3 clock the register from `gclk[0]` to `gclk[3]`, and value 4 clocks it from `pt_clk`. Values 5 to 7 select no clock, so the register holds. Clocks that are not selected have no effect.
- R6: With `clk_inv` = 0 the register captures on the rising edge of the selected clock. With `clk_inv` = 1 it captures on the falling edge.
- R7: `clr_sel` picks the clear source: 0 or 3 is ground, 1 is `prc[0]`, 2 is `prc[1]`. A high selected clear forces the register to 0 at once, without a clock.
- R8: `set_sel` uses the same encoding as `clr_sel` and forces the register to 1 at once, without a clock.
- R9: While clear and preset are both high, the register is 0.
- R10: With `xor_sel` = 3, each captured edge inverts the register when the sum is 1 and leaves it unchanged when the sum is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 4 | Global clocks |
| pt_clk | input | 1 | Product-term clock |
| pt_in | input | 16 | Product-term inputs |
| pt_en | input | 16 | Per-term enable bits |
| cpt0 | input | 1 | Carry term chosen without carry-in |
| cpt1 | input | 1 | Carry term chosen with carry-in |
| carry_in | input | 1 | Carry from the previous cell |
| chain_en | input | 1 | Lets the incoming carry through |
| prc | input | 2 | Preset/clear control product terms |
| set_sel | input | 2 | Preset source select |
| clr_sel | input | 2 | Clear source select |
| clk_sel | input | 3 | Register clock source select |
| clk_inv | input | 1 | 1 selects falling-edge capture |
| xor_sel | input | 2 | Second XOR input select |
| out_reg | input | 1 | 1 selects the registered output |
| cell_out | output | 1 | Cell output |
| carry_out | output | 1 | Carry to the next cell |

## Verification
The two functions that can coincide are the asynchronous preset and the asynchronous clear. The bench routes both to control terms and raises the two terms in the same step, then expects the registered output to read 0. It releases preset before clear, and the register must stay at 0 with no clock edge. A second overlap occurs when the toggle feedback and an edge land together: the register's own output feeds the XOR on the same edge that captures it. The bench checks each successive value against an alternating expectation.

// File: rtl/mc_pkg.sv
package mc_pkg;

  // Second XOR operand
  typedef enum logic [1:0] {
    XS_TRUE   = 2'd0,
    XS_INV    = 2'd1,
    XS_CARRY  = 2'd2,
    XS_TOGGLE = 2'd3
  } xin_sel_e;

  // Preset / clear source
  typedef enum logic [1:0] {
    SRC_GND0  = 2'd0,
    SRC_TERM0 = 2'd1,
    SRC_TERM1 = 2'd2,
    SRC_GND1  = 2'd3
  } ctl_src_e;

  function automatic logic pick_ctl(input ctl_src_e s, input logic [1:0] terms);
    case (s)
      SRC_TERM0: pick_ctl = terms[0];
      SRC_TERM1: pick_ctl = terms[1];
      default:   pick_ctl = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/mc_sum_term.sv
module mc_sum_term #(
  parameter int NPT = 16
) (
  input  logic [NPT-1:0] pt_in,
  input  logic [NPT-1:0] pt_en,
  output logic           sum
);
  logic [NPT-1:0] gated;

  for (genvar i = 0; i < NPT; i++) begin : g_term
    assign gated[i] = pt_in[i] & pt_en[i];
  end

  assign sum = |gated;
endmodule

// File: rtl/mc_xor_carry.sv
module mc_xor_carry
  import mc_pkg::*;
(
  input  logic     sum,
  input  logic     q,
  input  logic     cpt0,
  input  logic     cpt1,
  input  logic     carry_in,
  input  logic     chain_en,
  input  xin_sel_e xsel,
  output logic     xor_out,
  output logic     carry_out
);
  logic cin_gated;
  logic local_carry;
  logic xin;

  assign cin_gated   = carry_in & chain_en;
  assign local_carry = cin_gated ? cpt1 : cpt0;
  assign carry_out   = local_carry;

  always_comb begin
    case (xsel)
      XS_TRUE:   xin = 1'b0;
      XS_INV:    xin = 1'b1;
      XS_CARRY:  xin = local_carry;
      default:   xin = q;
    endcase
  end

  assign xor_out = sum ^ xin;
endmodule

// File: rtl/mc_cell_reg.sv
module mc_cell_reg
  import mc_pkg::*;
#(
  parameter int NGCLK = 4,
  parameter int SELW  = $clog2(NGCLK + 2)
) (
  input  logic [NGCLK-1:0] gclk,
  input  logic             pt_clk,
  input  logic [SELW-1:0]  clk_sel,
  input  logic             clk_inv,
  input  logic [1:0]       prc,
  input  ctl_src_e         set_sel,
  input  ctl_src_e         clr_sel,
  input  logic             d,
  output logic             q,
  output logic             set_act,
  output logic             clr_act
);
  logic src_clk;
  logic clk_eff;

  always_comb begin
    src_clk = 1'b0;
    for (int i = 0; i < NGCLK; i++) begin
      if (clk_sel == SELW'(i)) src_clk = gclk[i];
    end
    if (clk_sel == SELW'(NGCLK)) src_clk = pt_clk;
  end

  assign clk_eff = src_clk ^ clk_inv;
  assign set_act = pick_ctl(set_sel, prc);
  assign clr_act = pick_ctl(clr_sel, prc);

  always_ff @(posedge clk_eff or posedge clr_act or posedge set_act) begin
    if (clr_act)      q <= 1'b0;
    else if (set_act) q <= 1'b1;
    else              q <= d;
  end
endmodule

// File: rtl/pterm_macrocell.sv
module pterm_macrocell
  import mc_pkg::*;
#(
  parameter int NPT   = 16,
  parameter int NGCLK = 4,
  localparam int SELW = $clog2(NGCLK + 2)
) (
  input  logic [NGCLK-1:0] gclk,
  input  logic             pt_clk,
  input  logic [NPT-1:0]   pt_in,
  input  logic [NPT-1:0]   pt_en,
  input  logic             cpt0,
  input  logic             cpt1,
  input  logic             carry_in,
  input  logic             chain_en,
  input  logic [1:0]       prc,
  input  logic [1:0]       set_sel,
  input  logic [1:0]       clr_sel,
  input  logic [SELW-1:0]  clk_sel,
  input  logic             clk_inv,
  input  logic [1:0]       xor_sel,
  input  logic             out_reg,
  output logic             cell_out,
  output logic             carry_out
);
  logic sum_w;
  logic comb_w;
  logic reg_q;
  logic set_act;
  logic clr_act;

  mc_sum_term #(.NPT(NPT)) u_sum (
    .pt_in (pt_in),
    .pt_en (pt_en),
    .sum   (sum_w)
  );

  mc_xor_carry u_xor (
    .sum       (sum_w),
    .q         (reg_q),
    .cpt0      (cpt0),
    .cpt1      (cpt1),
    .carry_in  (carry_in),
    .chain_en  (chain_en),
    .xsel      (xin_sel_e'(xor_sel)),
    .xor_out   (comb_w),
    .carry_out (carry_out)
  );

  mc_cell_reg #(.NGCLK(NGCLK), .SELW(SELW)) u_reg (
    .gclk    (gclk),
    .pt_clk  (pt_clk),
    .clk_sel (clk_sel),
    .clk_inv (clk_inv),
    .prc     (prc),
    .set_sel (ctl_src_e'(set_sel)),
    .clr_sel (ctl_src_e'(clr_sel)),
    .d       (comb_w),
    .q       (reg_q),
    .set_act (set_act),
    .clr_act (clr_act)
  );

  assign cell_out = out_reg ? reg_q : comb_w;
endmodule

// File: rtl/mc_checker.sv
module mc_checker #(
  parameter int NPT  = 16,
  parameter int SELW = 3
) (
  input logic            clk,
  input logic [NPT-1:0]  pt_en,
  input logic            out_reg,
  input logic [1:0]      xor_sel,
  input logic            cell_out,
  input logic            carry_out,
  input logic            cpt0,
  input logic            chain_en,
  input logic            set_act,
  input logic            clr_act,
  input logic            q,
  input logic            sum,
  input logic [SELW-1:0] clk_sel,
  input logic            clk_inv
);
  // R7 / R9: an active clear holds the register at 0
  assert_clear_wins_R9: assert property (@(posedge clk)
    clr_act |-> (q == 1'b0));

  // R8: preset alone holds the register at 1
  assert_preset_R8: assert property (@(posedge clk)
    (set_act && !clr_act) |-> (q == 1'b1));

  // R1: with every term disabled the true-polarity output is 0
  assert_disabled_terms_R1: assert property (@(posedge clk)
    (pt_en == '0 && !out_reg && xor_sel == 2'd0) |-> (cell_out == 1'b0));

  // R3: a blocked chain passes the no-carry term
  assert_chain_cut_R3: assert property (@(posedge clk)
    !chain_en |-> (carry_out == cpt0));

  // R10: toggle mode inverts on a captured edge while the sum is 1
  assert_toggle_R10: assert property (@(posedge clk) disable iff (set_act || clr_act)
    (clk_sel == '0 && !clk_inv && xor_sel == 2'd3 && sum && !$isunknown(q))
      |=> (q != $past(q)));
endmodule

bind pterm_macrocell mc_checker #(.NPT(NPT), .SELW(SELW)) u_chk (
  .clk       (gclk[0]),
  .pt_en     (pt_en),
  .out_reg   (out_reg),
  .xor_sel   (xor_sel),
  .cell_out  (cell_out),
  .carry_out (carry_out),
  .cpt0      (cpt0),
  .chain_en  (chain_en),
  .set_act   (set_act),
  .clr_act   (clr_act),
  .q         (reg_q),
  .sum       (sum_w),
  .clk_sel   (clk_sel),
  .clk_inv   (clk_inv)
);

// File: tb/test_pterm_macrocell.sv
module test_pterm_macrocell;
  logic        clk100 = 1'b0;
  logic [2:0]  man_clk = 3'b000;
  logic [3:0]  gclk;
  logic        pt_clk = 1'b0;
  logic [15:0] pt_in = '0, pt_en = '0;
  logic        cpt0 = 0, cpt1 = 0, carry_in = 0, chain_en = 0;
  logic [1:0]  prc = 0, set_sel = 0, clr_sel = 0, xor_sel = 0;
  logic [2:0]  clk_sel = 3'd5;
  logic        clk_inv = 0, out_reg = 0;
  logic        cell_out, carry_out;
  int checks = 0, fails = 0;

  assign gclk = {man_clk, clk100};
  always #5 clk100 = ~clk100;

  pterm_macrocell i_pterm_macrocell (
    .gclk(gclk), .pt_clk(pt_clk), .pt_in(pt_in), .pt_en(pt_en),
    .cpt0(cpt0), .cpt1(cpt1), .carry_in(carry_in), .chain_en(chain_en),
    .prc(prc), .set_sel(set_sel), .clr_sel(clr_sel), .clk_sel(clk_sel),
    .clk_inv(clk_inv), .xor_sel(xor_sel), .out_reg(out_reg),
    .cell_out(cell_out), .carry_out(carry_out)
  );

  // {pt_in, pt_en, xor_sel, carry_in, chain_en, cpt0, cpt1, exp_out, exp_carry}
  localparam int NV = 11;
  localparam logic [39:0] VEC [NV] = '{
    {16'h0000, 16'hFFFF, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {16'h0001, 16'hFFFF, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'h8000, 16'h7FFF, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {16'h8000, 16'h8000, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {16'h0000, 16'hFFFF, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'hFFFF, 16'h0000, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'h0000, 16'hFFFF, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    {16'h0000, 16'hFFFF, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {16'h0010, 16'h0010, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    {16'h0400, 16'hFFFF, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {16'h00F0, 16'h0F0F, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic neg; @(negedge clk100); endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // Combinational path walk (R1, R2, R3, R4)
    for (int v = 0; v < NV; v++) begin
      neg;
      {pt_in, pt_en, xor_sel, carry_in, chain_en, cpt0, cpt1} = VEC[v][39:2];
      #2;
      chk($sformatf("R1/R2/R4 vec%0d out", v), cell_out, VEC[v][1]);
      chk($sformatf("R3 vec%0d carry", v), carry_out, VEC[v][0]);
    end

    // Register view, no clock selected
    neg;
    carry_in = 0; chain_en = 0; cpt0 = 0; cpt1 = 0;
    pt_en = 16'hFFFF; pt_in = 0; xor_sel = 0; out_reg = 1; clk_sel = 3'd5;
    clr_sel = 2'd1; set_sel = 2'd2;
    prc = 2'b01; #2;
    chk("R7 clear via term0", cell_out, 1'b0);
    prc = 2'b00; #2;
    prc = 2'b10; #2;
    chk("R8 preset via term1", cell_out, 1'b1);
    prc = 2'b00; #2;
    neg; neg;
    chk("R5 no clock holds", cell_out, 1'b1);
    prc = 2'b11; #2;
    chk("R9 clear beats preset", cell_out, 1'b0);
    prc = 2'b01; #2; prc = 2'b00; #2;
    chk("R9 after release", cell_out, 1'b0);
    clr_sel = 2'd3; set_sel = 2'd0; prc = 2'b11; #2;
    chk("R7 ground source ignored", cell_out, 1'b0);
    prc = 2'b00;

    // gclk[2], rising then falling (R5, R6)
    clk_sel = 3'd2; clk_inv = 0; pt_in = 16'h0001; #2;
    man_clk[1] = 1; #2;
    chk("R6 rising capture", cell_out, 1'b1);
    pt_in = 0; #2; man_clk[1] = 0; #2;
    chk("R6 falling ignored", cell_out, 1'b1);
    man_clk[1] = 1; #2;
    chk("R5 gclk2 capture 0", cell_out, 1'b0);
    clk_inv = 1; #2;
    pt_in = 16'h0001; #2; man_clk[1] = 0; #2;
    chk("R6 inverted falling capture", cell_out, 1'b1);
    pt_in = 0; #2; man_clk[1] = 1; #2;
    chk("R6 inverted rising ignored", cell_out, 1'b1);

    // Product-term clock (R5)
    clk_inv = 0; clk_sel = 3'd4; #2;
    pt_in = 0; #2; pt_clk = 1; #2;
    chk("R5 pt_clk capture", cell_out, 1'b0);
    pt_clk = 0; pt_in = 16'h0001; #2;
    man_clk[0] = 1; #2; man_clk[0] = 0; #2;
    chk("R5 unselected gclk1 ignored", cell_out, 1'b0);
    pt_clk = 1; #2; pt_clk = 0; #2;
    chk("R5 pt_clk capture 1", cell_out, 1'b1);

    // No clock selected (R5)
    clk_sel = 3'd5; pt_in = 0; #2;
    man_clk = 3'b111; pt_clk = 1; #2; man_clk = 3'b000; pt_clk = 0;
    neg; neg;
    chk("R5 none select holds", cell_out, 1'b1);

    // gclk[0] with toggle (R5, R10)
    neg; clk_sel = 3'd0;
    neg; #1;
    chk("R5 gclk0 capture", cell_out, 1'b0);
    xor_sel = 2'd3; pt_in = 16'h0100;
    neg; #1; chk("R10 toggle 1", cell_out, 1'b1);
    neg; #1; chk("R10 toggle 2", cell_out, 1'b0);
    neg; #1; chk("R10 toggle 3", cell_out, 1'b1);
    pt_in = 0;
    neg; #1; chk("R10 hold a", cell_out, 1'b1);
    neg; #1; chk("R10 hold b", cell_out, 1'b1);
    clk_sel = 3'd5;
    // Combinational view of the toggle XOR: sum 1 ^ q 1
    pt_in = 16'h0100; out_reg = 0; #2;
    chk("R2/R4 comb toggle path", cell_out, 1'b0);
    out_reg = 1; #2;
    chk("R4 register view", cell_out, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule